// File: doc/BRIEF.md
# Locker access code checker

This block decides whether a locker may be opened. A user first types a three-digit password on a keypad. The keypad encoder presents each key as a BCD nibble, together with a data-available strobe. The block then waits for the user's card to send a one-byte identifier over an asynchronous serial line running at 2400 baud, 8N1.

An enrolment table, set by parameters, pairs each locker with one password and one card code. When the password matches an entry and the card byte then matches that same entry, the block energises that locker's relay output and its indicator LED for a programmable hold time. Any mismatch drives the buzzer and the red alarm LED for a fixed alarm time, and no relay fires.

A 2-bit status code tells a display which of four outcomes holds:

| Code | Meaning |
|------|---------|
| 0 | idle |
| 1 | wrong password |
| 2 | granted |
| 3 | wrong card |

Top module: `locker_access_top`

## Requirements
- R1: The serial receiver decodes 8N1 frames, least significant bit first. It works at 16 times the baud rate, with a divisor of CLK_HZ/(BAUD*16) clock cycles per sample tick, and samples each bit near its middle.
- R2: A frame whose stop bit reads 0 is discarded and does not count as a card read. The receiver then waits for the line to return high before it looks for the next start bit. A relay never turns on without a valid card byte in the cycle before.
- R3: A keypad digit is captured once on each 0-to-1 transition of the data-available strobe, however long the strobe stays high. Three digits form the password, with the first digit in the most significant nibble. While the block waits for a card, status stays 0.
- R4: The password is compared against every table entry. When two entries share a password, the entry with the lowest index is selected.
- R5: A password that matches no entry starts an alarm with status 1, and no card is awaited.
- R6: After a password match, the next valid card byte is compared with the card code of the selected entry. On a match, relay_o[k] and led_o[k] turn on for exactly HOLD_CYCLES clock cycles with status 2, at most one relay at a time. The block then returns to idle with status 0.
- R7: A card byte that differs from the selected entry's code starts an alarm with status 3.
- R8: During an alarm, buzzer_o and red_led_o are 1 for exactly ALARM_CYCLES clock cycles and every relay is off. Status is 1 or 3 throughout, and it returns to 0 when the alarm ends.
- R9: Card bytes that arrive while no password is pending have no effect. Keypad strobes that arrive while a card is awaited, a locker is open or an alarm is sounding are dropped, and no partial password survives into the next entry.
- R10: After reset, all relays, LEDs and the buzzer are off and status is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from the card, idles high |
| key_digit_i | input | 4 | BCD value of the pressed key |
| key_valid_i | input | 1 | Data-available strobe from the keypad encoder |
| relay_o | output | NUM_LOCKERS | One relay drive per locker |
| led_o | output | NUM_LOCKERS | One indicator LED per locker |
| red_led_o | output | 1 | Red alarm LED |
| buzzer_o | output | 1 | Buzzer drive |
| status_o | output | 2 | Status code: 0 idle, 1 wrong password, 2 granted, 3 wrong card |

## Verification
The bench sends a frame whose stop bit is held low, then sends a good frame. A receiver that accepted the bad frame would open or alarm early, and one that re-armed on the still-low line would lose the following frame.

Several tests target the keypad path:
- A key is held high for a long time. A design that captured on level rather than on the edge would fill the password with repeats and raise status 1.
- Two stray digits are pressed while a locker is open. A design that collected them would report a wrong password on the next clean entry.
- A duplicated password is paired with the card of the higher-index entry. This must give status 3, which exposes a wrong priority order.

The exact relay and alarm durations are counted cycle by cycle, to catch off-by-one timers.

// File: rtl/locker_pkg.sv
package locker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_BAD_PW   = 2'd1,
    ST_GRANT    = 2'd2,
    ST_BAD_CARD = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    CK_IDLE,
    CK_CARD,
    CK_OPEN,
    CK_ALARM
  } chk_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HUNT
  } rx_state_e;
endpackage

// File: rtl/locker_uart_rx.sv
module locker_uart_rx #(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int unsigned BAUD   = 2400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  import locker_pkg::*;

  localparam int unsigned OVS   = 16;
  localparam int unsigned DIV   = CLK_HZ / (BAUD * OVS);
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [1:0]       rx_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       ovs_q;
  logic [2:0]       bit_q;
  logic [7:0]       shf_q;
  logic             tick;

  assign rx_s   = rx_q[1];
  assign tick   = (div_q == DIV_W'(DIV - 1));
  assign data_o = shf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 2'b11;
    else         rx_q <= {rx_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      div_q   <= '0;
      ovs_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          div_q <= '0;
          ovs_q <= '0;
          bit_q <= '0;
          if (!rx_s) st_q <= RX_START;
        end
        // after a framing error, wait for the line to go high again
        RX_HUNT: if (rx_s) st_q <= RX_IDLE;
        default: begin
          div_q <= tick ? '0 : div_q + 1'b1;
          if (tick) begin
            ovs_q <= ovs_q + 1'b1;
            case (st_q)
              RX_START: if (ovs_q == 4'd7) begin
                ovs_q <= '0;
                st_q  <= rx_s ? RX_IDLE : RX_DATA;
              end
              RX_DATA: if (ovs_q == 4'd15) begin
                shf_q <= {rx_s, shf_q[7:1]};
                bit_q <= bit_q + 1'b1;
                if (bit_q == 3'd7) st_q <= RX_STOP;
              end
              RX_STOP: if (ovs_q == 4'd15) begin
                if (rx_s) begin
                  valid_o <= 1'b1;
                  st_q    <= RX_IDLE;
                end else begin
                  st_q    <= RX_HUNT;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/locker_digit_collect.sv
module locker_digit_collect #(
  parameter int unsigned DIGITS = 3,
  localparam int unsigned PW_W  = DIGITS * 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [3:0]      digit_i,
  input  logic            strobe_i,
  output logic [PW_W-1:0] pw_o,
  output logic            done_o
);
  localparam int unsigned CNT_W = $clog2(DIGITS + 1);

  logic [2:0]       stb_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;
  logic [PW_W-1:0]  pw_q;

  assign rise = stb_q[1] & ~stb_q[2];
  assign pw_o = pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= '0;
    else         stb_q <= {stb_q[1:0], strobe_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pw_q   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (rise) begin
        pw_q <= {pw_q[PW_W-5:0], digit_i};
        if (cnt_q == CNT_W'(DIGITS - 1)) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/locker_access_ctrl.sv
module locker_access_ctrl #(
  parameter int unsigned NUM_LOCKERS  = 4,
  parameter int unsigned PW_W         = 12,
  parameter logic [NUM_LOCKERS*8-1:0]    CARD_TABLE = '0,
  parameter logic [NUM_LOCKERS*PW_W-1:0] PW_TABLE   = '0,
  parameter int unsigned HOLD_CYCLES  = 100,
  parameter int unsigned ALARM_CYCLES = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PW_W-1:0]        pw_i,
  input  logic                   pw_done_i,
  input  logic [7:0]             card_i,
  input  logic                   card_vld_i,
  output logic                   collect_o,
  output logic [NUM_LOCKERS-1:0] relay_o,
  output logic [NUM_LOCKERS-1:0] led_o,
  output logic                   red_led_o,
  output logic                   buzzer_o,
  output logic [1:0]             status_o
);
  import locker_pkg::*;

  localparam int unsigned TMR_MAX = (HOLD_CYCLES > ALARM_CYCLES) ? HOLD_CYCLES : ALARM_CYCLES;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned IDX_W   = (NUM_LOCKERS > 1) ? $clog2(NUM_LOCKERS) : 1;

  chk_state_e             st_q;
  status_e                stat_q;
  logic [IDX_W-1:0]       sel_q;
  logic [TMR_W-1:0]       tmr_q;
  logic [NUM_LOCKERS-1:0] pw_hit;
  logic                   hit_any;
  logic [IDX_W-1:0]       hit_idx;
  logic                   card_ok;

  for (genvar g = 0; g < NUM_LOCKERS; g++) begin : g_cmp
    assign pw_hit[g] = (PW_TABLE[g*PW_W +: PW_W] == pw_i);
  end

  // lowest index wins on duplicate passwords
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_LOCKERS - 1; i >= 0; i--) begin
      if (pw_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |pw_hit;
  assign card_ok = (card_i == CARD_TABLE[sel_q*8 +: 8]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CK_IDLE;
      stat_q <= ST_IDLE;
      sel_q  <= '0;
      tmr_q  <= '0;
    end else begin
      case (st_q)
        CK_IDLE: if (pw_done_i) begin
          tmr_q <= '0;
          if (hit_any) begin
            sel_q <= hit_idx;
            st_q  <= CK_CARD;
          end else begin
            st_q   <= CK_ALARM;
            stat_q <= ST_BAD_PW;
          end
        end
        CK_CARD: if (card_vld_i) begin
          tmr_q <= '0;
          if (card_ok) begin
            st_q   <= CK_OPEN;
            stat_q <= ST_GRANT;
          end else begin
            st_q   <= CK_ALARM;
            stat_q <= ST_BAD_CARD;
          end
        end
        CK_OPEN: begin
          if (tmr_q == TMR_W'(HOLD_CYCLES - 1)) begin
            st_q   <= CK_IDLE;
            stat_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          if (tmr_q == TMR_W'(ALARM_CYCLES - 1)) begin
            st_q   <= CK_IDLE;
            stat_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign collect_o = (st_q == CK_IDLE);
  assign relay_o   = (st_q == CK_OPEN) ? (NUM_LOCKERS'(1) << sel_q) : '0;
  assign led_o     = relay_o;
  assign buzzer_o  = (st_q == CK_ALARM);
  assign red_led_o = (st_q == CK_ALARM);
  assign status_o  = stat_q;
endmodule

// File: rtl/locker_access_top.sv
module locker_access_top #(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned BAUD         = 2400,
  parameter int unsigned NUM_LOCKERS  = 4,
  parameter int unsigned PW_DIGITS    = 3,
  parameter int unsigned HOLD_CYCLES  = 250_000_000,
  parameter int unsigned ALARM_CYCLES = 750_000_000,
  parameter logic [NUM_LOCKERS*8-1:0]           CARD_TABLE = 32'h81_5A_3C_A4,
  parameter logic [NUM_LOCKERS*PW_DIGITS*4-1:0] PW_TABLE   = 48'h123_789_456_123
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rx_i,
  input  logic [3:0]             key_digit_i,
  input  logic                   key_valid_i,
  output logic [NUM_LOCKERS-1:0] relay_o,
  output logic [NUM_LOCKERS-1:0] led_o,
  output logic                   red_led_o,
  output logic                   buzzer_o,
  output logic [1:0]             status_o
);
  localparam int unsigned PW_W = PW_DIGITS * 4;

  logic [7:0]      card_byte;
  logic            card_vld;
  logic [PW_W-1:0] pw;
  logic            pw_done;
  logic            collect;

  locker_uart_rx #(
    .CLK_HZ (CLK_HZ),
    .BAUD   (BAUD)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .data_o  (card_byte),
    .valid_o (card_vld)
  );

  locker_digit_collect #(
    .DIGITS (PW_DIGITS)
  ) u_keys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (collect),
    .digit_i  (key_digit_i),
    .strobe_i (key_valid_i),
    .pw_o     (pw),
    .done_o   (pw_done)
  );

  locker_access_ctrl #(
    .NUM_LOCKERS  (NUM_LOCKERS),
    .PW_W         (PW_W),
    .CARD_TABLE   (CARD_TABLE),
    .PW_TABLE     (PW_TABLE),
    .HOLD_CYCLES  (HOLD_CYCLES),
    .ALARM_CYCLES (ALARM_CYCLES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pw_i       (pw),
    .pw_done_i  (pw_done),
    .card_i     (card_byte),
    .card_vld_i (card_vld),
    .collect_o  (collect),
    .relay_o    (relay_o),
    .led_o      (led_o),
    .red_led_o  (red_led_o),
    .buzzer_o   (buzzer_o),
    .status_o   (status_o)
  );
endmodule

// File: rtl/locker_access_chk.sv
module locker_access_chk #(
  parameter int unsigned NUM_LOCKERS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_LOCKERS-1:0] relay_o,
  input logic                   buzzer_o,
  input logic [1:0]             status_o,
  input logic                   card_vld
);
  // R6
  relay_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(relay_o));

  // R6
  open_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relay_o != '0) |-> (status_o == 2'd2));

  // R8
  alarm_no_relay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buzzer_o |-> (relay_o == '0));

  // R8
  alarm_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buzzer_o |-> (status_o == 2'd1 || status_o == 2'd3));

  // R8
  alarm_end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buzzer_o) |-> (status_o == 2'd0));

  // R2
  open_needs_card_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((relay_o != '0) && ($past(relay_o) == '0)) |-> $past(card_vld));
endmodule

bind locker_access_top locker_access_chk #(
  .NUM_LOCKERS (NUM_LOCKERS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .relay_o  (relay_o),
  .buzzer_o (buzzer_o),
  .status_o (status_o),
  .card_vld (card_vld)
);

// File: tb/tb_locker_access_top.sv
`timescale 1ns/1ps
module tb_locker_access_top;
  localparam int unsigned CLK_HZ = 614_400;
  localparam int unsigned BAUD   = 2400;
  localparam int unsigned BIT    = CLK_HZ / BAUD;
  localparam int unsigned HOLD   = 300;
  localparam int unsigned ALARM  = 150;
  localparam int unsigned NL     = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic [3:0]    digit = '0;
  logic          kvalid = 1'b0;
  logic [NL-1:0] relay, led;
  logic          red, buzz;
  logic [1:0]    status;

  int checks = 0;
  int errors = 0;
  int open_cnt = 0;
  int alarm_cnt = 0;

  always #2 clk = ~clk;

  locker_access_top #(
    .CLK_HZ       (CLK_HZ),
    .BAUD         (BAUD),
    .NUM_LOCKERS  (NL),
    .PW_DIGITS    (3),
    .HOLD_CYCLES  (HOLD),
    .ALARM_CYCLES (ALARM),
    .CARD_TABLE   (32'h81_5A_3C_A4),
    .PW_TABLE     (48'h123_789_456_123)
  ) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .key_digit_i (digit),
    .key_valid_i (kvalid),
    .relay_o     (relay),
    .led_o       (led),
    .red_led_o   (red),
    .buzzer_o    (buzz),
    .status_o    (status)
  );

  always @(negedge clk) begin
    if (relay != '0) open_cnt++;
    if (buzz) alarm_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] d, input int hold);
    @(negedge clk);
    digit  = d;
    kvalid = 1'b1;
    repeat (hold) @(negedge clk);
    kvalid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic enter3(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    press(a, 6);
    press(b, 6);
    press(c, 6);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop_bit);
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stop_bit;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (status == 2'd0 && !buzz && relay == '0) break;
    end
  endtask

  task automatic do_grant(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                          input logic [7:0] card, input int k, input string tag);
    int base;
    base = open_cnt;
    enter3(a, b, c);
    repeat (20) @(negedge clk);
    chk({tag, " R3 waiting status"}, status, 2'd0);
    chk({tag, " R3 no alarm while waiting"}, buzz, 1'b0);
    send_byte(card, 1'b1);
    repeat (2) @(negedge clk);
    chk({tag, " R6 relay"}, relay, NL'(1) << k);
    chk({tag, " R6 led"}, led, NL'(1) << k);
    chk({tag, " R6 status granted"}, status, 2'd2);
    wait_idle();
    chk({tag, " R6 hold length"}, open_cnt - base, HOLD);
    chk({tag, " R6 back to idle"}, status, 2'd0);
  endtask

  task automatic t_reset;
    chk("R10 relay", relay, '0);
    chk("R10 led", led, '0);
    chk("R10 buzzer", buzz, 1'b0);
    chk("R10 red", red, 1'b0);
    chk("R10 status", status, 2'd0);
  endtask

  task automatic t_bad_pw;
    int base;
    base = alarm_cnt;
    enter3(4'd9, 4'd9, 4'd9);
    chk("R5 status wrong pw", status, 2'd1);
    chk("R8 buzzer on", buzz, 1'b1);
    chk("R8 red on", red, 1'b1);
    chk("R8 relays off", relay, '0);
    wait_idle();
    chk("R8 alarm length", alarm_cnt - base, ALARM);
    chk("R8 status idle after alarm", status, 2'd0);
  endtask

  task automatic t_bad_card(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                            input logic [7:0] card, input string tag);
    int base;
    base = alarm_cnt;
    enter3(a, b, c);
    send_byte(card, 1'b1);
    repeat (2) @(negedge clk);
    chk({tag, " status wrong card"}, status, 2'd3);
    chk({tag, " buzzer"}, buzz, 1'b1);
    chk({tag, " relays off"}, relay, '0);
    wait_idle();
    chk({tag, " R8 alarm length"}, alarm_cnt - base, ALARM);
  endtask

  task automatic t_bad_stop;
    enter3(4'd4, 4'd5, 4'd6);
    send_byte(8'h3C, 1'b0);
    repeat (50) @(negedge clk);
    chk("R2 bad frame no relay", relay, '0);
    chk("R2 bad frame no alarm", buzz, 1'b0);
    chk("R2 bad frame status", status, 2'd0);
    send_byte(8'h3C, 1'b1);
    repeat (2) @(negedge clk);
    chk("R2 R1 good frame opens locker1", relay, 4'b0010);
    wait_idle();
  endtask

  task automatic t_idle_card;
    send_byte(8'hA4, 1'b1);
    repeat (20) @(negedge clk);
    chk("R9 idle card no relay", relay, '0);
    chk("R9 idle card no alarm", buzz, 1'b0);
    do_grant(4'd1, 4'd2, 4'd3, 8'hA4, 0, "R9 after idle card");
  endtask

  task automatic t_held_key;
    press(4'd1, 200);
    press(4'd2, 6);
    press(4'd3, 6);
    repeat (20) @(negedge clk);
    chk("R3 held key counted once", status, 2'd0);
    send_byte(8'hA4, 1'b1);
    repeat (2) @(negedge clk);
    chk("R3 held key grant", relay, 4'b0001);
    wait_idle();
  endtask

  task automatic t_keys_while_open;
    enter3(4'd7, 4'd8, 4'd9);
    send_byte(8'h5A, 1'b1);
    repeat (2) @(negedge clk);
    chk("R6 locker2 open", relay, 4'b0100);
    press(4'd4, 6);
    press(4'd5, 6);
    wait_idle();
    chk("R9 stray keys no alarm", buzz, 1'b0);
    do_grant(4'd7, 4'd8, 4'd9, 8'h5A, 2, "R9 clean entry after stray keys");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      begin
        t_reset();
        do_grant(4'd1, 4'd2, 4'd3, 8'hA4, 0, "R1 locker0");
        do_grant(4'd7, 4'd8, 4'd9, 8'h5A, 2, "R1 locker2");
        t_bad_pw();
        t_bad_card(4'd4, 4'd5, 4'd6, 8'hA4, "R7");
        // password 123 is in entries 0 and 3; entry 0 must win
        t_bad_card(4'd1, 4'd2, 4'd3, 8'h81, "R4 priority");
        t_bad_stop();
        t_idle_card();
        t_held_key();
        t_keys_while_open();
      end
      begin
        repeat (190_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule